// File: doc/BRIEF.md
# Oversampling Serial Receive Engine

This block turns an asynchronous serial line into a stream of stored characters. The line is sampled only on cycles where a 16x oversampling tick enable is high; the tick comes from a divider elsewhere whose ratio can be anything from 1 to 65535. A falling edge starts a frame. The start bit is confirmed half a bit later, and each following bit is sampled in the middle of its period. The number of data bits is selectable at run time, and so is the parity mode.

Each finished frame becomes one entry in a first-word-fall-through queue. An entry holds the data and three flags: parity error, framing error and break. The flags travel with the character and appear at the read port when that character reaches the head. If the queue is full, the new character is lost and a sticky overrun bit is raised.

A loopback select feeds the receiver from the local transmitter's serial output instead of the external pin. With loopback on, the link can be tested without anything attached to the pin.

Top module: `uart_rx_engine`

## Requirements
- R1: After reset the queue is empty (`fifo_empty`=1, `fifo_full`=0, `fifo_count`=0), and `overrun` and `line_break` are 0.
- R2: `width_sel` values 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits. Data bits arrive least significant bit first. They are stored right-aligned in `rd_data`, with the unused upper bits zero.
- R3: When `par_en`=1, one parity bit follows the data bits. With `par_odd`=0, the data bits plus the parity bit must hold an even number of ones; with `par_odd`=1 they must hold an odd number. If they do not, `rd_perr` is 1 for that entry. When `par_en`=0 no parity bit is expected and `rd_perr` is 0.
- R4: A low level that is no longer low 8 ticks after it was first seen is treated as a glitch. It stores nothing, and the next frame is received correctly.
- R5: If the first stop bit samples low while some data or parity bit was high, the entry is stored with `rd_ferr`=1. Reception resumes once the line is high again.
- R6: If every data, parity and stop sample is low, exactly one entry is stored, with `rd_data`=0, `rd_brk`=1, `rd_ferr`=0 and `rd_perr`=0. `line_break` stays 1 until the line returns high. The next frame after that is received normally.
- R7: The queue holds `FIFO_DEPTH` (64) entries and returns them in arrival order. `rd_en` while not empty removes the head entry. `fifo_count`, `fifo_full` and `fifo_empty` track the number of entries.
- R8: A character that completes while the queue is full (and no read happens in that cycle) is discarded, and `overrun` goes to 1. `overrun` stays 1 until the next read of an entry.
- R9: With `loop_en`=1 the receiver takes its input from `tx_loop`, and `rx_pin` has no effect. With `loop_en`=0, `tx_loop` has no effect.
- R10: The line is sampled only on cycles where `tick16` is high, and one bit lasts 16 ticks. With `tick16` held low, a frame on the line stores nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_pin | input | 1 | External serial input, idle high |
| tx_loop | input | 1 | Local transmitter serial output, used when looped back |
| loop_en | input | 1 | 1 selects `tx_loop` as the receive line |
| tick16 | input | 1 | Oversampling enable, 16 per bit |
| width_sel | input | 2 | Data bits minus 5 |
| par_en | input | 1 | A parity bit is present and checked |
| par_odd | input | 1 | 1 = odd parity, 0 = even |
| rd_en | input | 1 | Remove the head entry |
| rd_data | output | 8 | Head entry data, right-aligned |
| rd_perr | output | 1 | Head entry parity error |
| rd_ferr | output | 1 | Head entry framing error |
| rd_brk | output | 1 | Head entry is a break |
| fifo_empty | output | 1 | Queue holds no entries |
| fifo_full | output | 1 | Queue holds FIFO_DEPTH entries |
| fifo_count | output | CNT_W (7) | Number of stored entries |
| overrun | output | 1 | A character was lost to a full queue |
| line_break | output | 1 | A break is on the line now |

## Verification
The checks use all four character widths, with data chosen so that a wrong bit order, wrong alignment or missing zero-fill produces a different stored value. Correct and corrupted parity are both sent under even and odd modes, which separates the two polarities. A long low hold is compared with a low stop bit under nonzero data, which tells a break apart from a framing error. A short low pulse shows whether the start-bit recheck rejects glitches. A 65-character burst with reads stalled and a frame sent with the tick stopped cover queue capacity, the drop rule and tick gating. Frames sent on the unselected input, in both loopback states, show that the line select works.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

   localparam int CHAR_W = 8;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_DATA,
      ST_PAR,
      ST_STOP,
      ST_WAIT_HI,
      ST_BRK
   } rx_state_e;

   typedef struct packed {
      logic              brk;
      logic              ferr;
      logic              perr;
      logic [CHAR_W-1:0] data;
   } rx_entry_t;

   function automatic logic [3:0] width_bits(input logic [1:0] sel);
      return 4'd5 + {2'b00, sel};
   endfunction

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_in,
   output logic d_out
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("uart_rx_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   generate
      for (genvar g = 0; g < STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= RST_VAL;
               else        chain[0] <= d_in;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[g] <= RST_VAL;
               else        chain[g] <= chain[g-1];
            end
         end
      end
   endgenerate

   assign d_out = chain[STAGES-1];

endmodule

// File: rtl/uart_rx_deser.sv
module uart_rx_deser
   import uart_rx_pkg::*;
#(
   parameter int OVS = 16
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        tick,
   input  logic        line,
   input  logic [1:0]  width_sel,
   input  logic        par_en,
   input  logic        par_odd,
   output logic        push,
   output rx_entry_t   entry,
   output logic        in_break
);

   localparam int TW   = $clog2(OVS);
   localparam int HALF = OVS / 2;

   generate
      if (OVS < 4 || (1 << TW) != OVS) begin : g_bad_ovs
         $error("uart_rx_deser: OVS must be a power of two, at least 4");
      end
   endgenerate

   localparam logic [TW-1:0] LAST_T = TW'(OVS - 1);
   localparam logic [TW-1:0] MID_T  = TW'(HALF - 1);

   rx_state_e         state;
   logic [TW-1:0]     tcnt;
   logic [2:0]        bit_idx;
   logic [CHAR_W-1:0] shreg;
   logic              pbit;
   logic              saw_one;

   logic [3:0]        nbits;
   logic [CHAR_W-1:0] aligned;
   logic              par_bad;
   logic              at_end;

   always_comb begin
      nbits   = width_bits(width_sel);
      aligned = shreg >> (4'd8 - nbits);
      par_bad = par_en & ((^aligned) ^ pbit ^ par_odd);
      at_end  = tick && (tcnt == LAST_T);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         tcnt    <= '0;
         bit_idx <= '0;
         shreg   <= '0;
         pbit    <= 1'b0;
         saw_one <= 1'b0;
         push    <= 1'b0;
         entry   <= '0;
      end else begin
         push <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (tick && !line) begin
                  state <= ST_START;
                  tcnt  <= '0;
               end
            end
            ST_START: begin
               if (tick) begin
                  if (tcnt == MID_T) begin
                     tcnt    <= '0;
                     bit_idx <= '0;
                     shreg   <= '0;
                     pbit    <= 1'b0;
                     saw_one <= 1'b0;
                     state   <= line ? ST_IDLE : ST_DATA;
                  end else begin
                     tcnt <= tcnt + 1'b1;
                  end
               end
            end
            ST_DATA: begin
               if (at_end) begin
                  tcnt    <= '0;
                  shreg   <= {line, shreg[CHAR_W-1:1]};
                  saw_one <= saw_one | line;
                  if ({1'b0, bit_idx} == nbits - 4'd1)
                     state <= par_en ? ST_PAR : ST_STOP;
                  else
                     bit_idx <= bit_idx + 1'b1;
               end else if (tick) begin
                  tcnt <= tcnt + 1'b1;
               end
            end
            ST_PAR: begin
               if (at_end) begin
                  tcnt    <= '0;
                  pbit    <= line;
                  saw_one <= saw_one | line;
                  state   <= ST_STOP;
               end else if (tick) begin
                  tcnt <= tcnt + 1'b1;
               end
            end
            ST_STOP: begin
               if (at_end) begin
                  tcnt <= '0;
                  push <= 1'b1;
                  if (!line && !saw_one) begin
                     entry <= '{brk: 1'b1, ferr: 1'b0, perr: 1'b0, data: '0};
                     state <= ST_BRK;
                  end else begin
                     entry <= '{brk: 1'b0, ferr: !line, perr: par_bad, data: aligned};
                     state <= line ? ST_IDLE : ST_WAIT_HI;
                  end
               end else if (tick) begin
                  tcnt <= tcnt + 1'b1;
               end
            end
            ST_WAIT_HI, ST_BRK: begin
               if (line) state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign in_break = (state == ST_BRK);

   // R4: a high level at the start recheck abandons the frame
   p_glitch_reject_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_START && tick && tcnt == MID_T && line) |=> (state == ST_IDLE && !push));

   // R6: a break entry carries only the break flag and zero data
   p_break_clean_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (push && entry.brk) |-> (entry.data == '0 && !entry.perr && !entry.ferr));

   // R6: the break state is left only once the line is high
   p_break_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_BRK && !line) |=> (state == ST_BRK));

   // R10: an entry is produced only right after a tick
   p_push_on_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> $past(tick));

   // R2: stored data never has bits above the selected width
   p_width_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !entry.brk) |-> ((entry.data >> nbits) == '0));

endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
   parameter int DEPTH = 64,
   parameter int W     = 11,
   localparam int AW   = $clog2(DEPTH),
   localparam int CW   = AW + 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] wdata,
   input  logic         pop,
   output logic [W-1:0] rdata,
   output logic         empty,
   output logic         full,
   output logic [CW-1:0] count,
   output logic         overrun
);

   generate
      if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
         $error("uart_rx_fifo: DEPTH must be a power of two, at least 2");
      end
   endgenerate

   localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wptr, rptr;
   logic          do_pop, accept;

   assign empty  = (count == '0);
   assign full   = (count == FULL_CNT);
   assign do_pop = pop && !empty;
   assign accept = push && (!full || do_pop);
   assign rdata  = mem[rptr];

   always_ff @(posedge clk) begin
      if (accept) mem[wptr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr    <= '0;
         rptr    <= '0;
         count   <= '0;
         overrun <= 1'b0;
      end else begin
         if (accept) wptr <= wptr + 1'b1;
         if (do_pop) rptr <= rptr + 1'b1;
         unique case ({accept, do_pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
         if (push && !accept) overrun <= 1'b1;
         else if (do_pop)     overrun <= 1'b0;
      end
   end

   // R7: occupancy never exceeds the depth
   p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
      count <= FULL_CNT);

   // R8: a push into a full queue with no read is dropped and flagged
   p_drop_when_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !pop) |=> (overrun && full));

   // R7: reading the last entry empties the queue
   p_last_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && count == CW'(1) && !push) |=> empty);

   // R8: a read clears the loss flag unless a new loss happens at once
   p_overrun_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !empty && !push) |=> !overrun);

endmodule

// File: rtl/uart_rx_engine.sv
module uart_rx_engine
   import uart_rx_pkg::*;
#(
   parameter int FIFO_DEPTH  = 64,
   parameter int OVS         = 16,
   parameter int SYNC_STAGES = 2,
   localparam int CNT_W      = $clog2(FIFO_DEPTH) + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_pin,
   input  logic             tx_loop,
   input  logic             loop_en,
   input  logic             tick16,
   input  logic [1:0]       width_sel,
   input  logic             par_en,
   input  logic             par_odd,
   input  logic             rd_en,
   output logic [7:0]       rd_data,
   output logic             rd_perr,
   output logic             rd_ferr,
   output logic             rd_brk,
   output logic             fifo_empty,
   output logic             fifo_full,
   output logic [CNT_W-1:0] fifo_count,
   output logic             overrun,
   output logic             line_break
);

   localparam int ENTRY_W = $bits(rx_entry_t);

   logic      raw_line, line_s;
   logic      push;
   rx_entry_t wr_entry, head;

   assign raw_line = loop_en ? tx_loop : rx_pin;

   uart_rx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  (raw_line),
      .d_out (line_s)
   );

   uart_rx_deser #(.OVS(OVS)) u_deser (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick16),
      .line      (line_s),
      .width_sel (width_sel),
      .par_en    (par_en),
      .par_odd   (par_odd),
      .push      (push),
      .entry     (wr_entry),
      .in_break  (line_break)
   );

   uart_rx_fifo #(.DEPTH(FIFO_DEPTH), .W(ENTRY_W)) u_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .push    (push),
      .wdata   (wr_entry),
      .pop     (rd_en),
      .rdata   (head),
      .empty   (fifo_empty),
      .full    (fifo_full),
      .count   (fifo_count),
      .overrun (overrun)
   );

   assign rd_data = head.data;
   assign rd_perr = head.perr;
   assign rd_ferr = head.ferr;
   assign rd_brk  = head.brk;

   // R7: the two status flags are never both set
   p_flags_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(fifo_empty && fifo_full));

endmodule

// File: tb/uart_rx_engine_tb.sv
module uart_rx_engine_tb;
   import uart_rx_pkg::*;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_pin = 1'b1;
   logic       tx_loop = 1'b1;
   logic       loop_en = 1'b0;
   logic       tick16 = 1'b0;
   logic [1:0] width_sel = 2'd3;
   logic       par_en = 1'b0;
   logic       par_odd = 1'b0;
   logic       rd_en = 1'b0;
   logic [7:0] rd_data;
   logic       rd_perr, rd_ferr, rd_brk;
   logic       fifo_empty, fifo_full;
   logic [6:0] fifo_count;
   logic       overrun, line_break;

   int n_chk = 0;
   int n_bad = 0;
   int tick_div = 3;
   int tick_cnt = 0;
   bit mon_en = 1'b1;
   rx_entry_t exp_q[$];

   always #10 clk = ~clk;

   uart_rx_engine u_dut (
      .clk(clk), .rst_n(rst_n), .rx_pin(rx_pin), .tx_loop(tx_loop),
      .loop_en(loop_en), .tick16(tick16), .width_sel(width_sel),
      .par_en(par_en), .par_odd(par_odd), .rd_en(rd_en),
      .rd_data(rd_data), .rd_perr(rd_perr), .rd_ferr(rd_ferr), .rd_brk(rd_brk),
      .fifo_empty(fifo_empty), .fifo_full(fifo_full), .fifo_count(fifo_count),
      .overrun(overrun), .line_break(line_break)
   );

   always @(negedge clk) begin
      if (tick_div == 0) begin
         tick16 = 1'b0;
         tick_cnt = 0;
      end else if (tick_cnt >= tick_div - 1) begin
         tick16 = 1'b1;
         tick_cnt = 0;
      end else begin
         tick16 = 1'b0;
         tick_cnt = tick_cnt + 1;
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // monitor: compares the queue head against the scoreboard
   always @(negedge clk) begin
      if (rd_en) begin
         rd_en = 1'b0;
      end else if (mon_en && rst_n && !fifo_empty) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R7", "unexpected entry", {rd_brk, rd_ferr, rd_perr, rd_data}, 0);
         end else begin
            rx_entry_t e;
            e = exp_q.pop_front();
            check({rd_brk, rd_ferr, rd_perr, rd_data} == e, "R2/R3/R5/R6/R7",
                  "entry", {rd_brk, rd_ferr, rd_perr, rd_data}, e);
         end
         rd_en = 1'b1;
      end
   end

   function automatic int bit_clks();
      return (tick_div == 0) ? 48 : 16 * tick_div;
   endfunction

   task automatic drive_bit(input logic b, input bit via_loop);
      if (via_loop) tx_loop = b; else rx_pin = b;
      repeat (bit_clks()) @(negedge clk);
   endtask

   task automatic send_frame(input logic [7:0] d, input int nb, input bit flip_par,
                             input logic stop_lvl, input bit via_loop);
      logic p;
      p = par_odd;
      for (int i = 0; i < nb; i++) p ^= d[i];
      if (flip_par) p = ~p;
      drive_bit(1'b0, via_loop);
      for (int i = 0; i < nb; i++) drive_bit(d[i], via_loop);
      if (par_en) drive_bit(p, via_loop);
      drive_bit(stop_lvl, via_loop);
      drive_bit(1'b1, via_loop);
      drive_bit(1'b1, via_loop);
   endtask

   task automatic expect_item(input logic [7:0] d, input bit pe, input bit fe, input bit bk);
      rx_entry_t e;
      e.data = d; e.perr = pe; e.ferr = fe; e.brk = bk;
      exp_q.push_back(e);
   endtask

   task automatic drain(input string req);
      int guard;
      guard = 0;
      while ((exp_q.size() != 0 || !fifo_empty) && guard < 5000) begin
         @(negedge clk);
         guard++;
      end
      repeat (4) @(negedge clk);
      check(exp_q.size() == 0, req, "expected entries left", exp_q.size(), 0);
   endtask

   task automatic send_ok(input logic [7:0] d, input int nb);
      logic [7:0] m;
      m = 8'hFF >> (8 - nb);
      expect_item(d & m, 1'b0, 1'b0, 1'b0);
      send_frame(d, nb, 1'b0, 1'b1, 1'b0);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (5) @(negedge clk);
      // R1 reset state
      check(fifo_empty == 1'b1, "R1", "empty", fifo_empty, 1);
      check(fifo_full == 1'b0, "R1", "full", fifo_full, 0);
      check(fifo_count == 0, "R1", "count", fifo_count, 0);
      check(overrun == 1'b0 && line_break == 1'b0, "R1", "status", {overrun, line_break}, 0);
      rst_n = 1'b1;
      repeat (20) @(negedge clk);

      // R2: 8-bit frames, then narrower widths
      width_sel = 2'd3;
      send_ok(8'h55, 8); send_ok(8'hA3, 8); send_ok(8'h00, 8); send_ok(8'hFF, 8);
      width_sel = 2'd0; send_ok(8'h1B, 5); send_ok(8'hF4, 5);
      width_sel = 2'd1; send_ok(8'h2D, 6); send_ok(8'h3F, 6);
      width_sel = 2'd2; send_ok(8'h4E, 7); send_ok(8'h71, 7);
      drain("R2");

      // R3: parity modes
      width_sel = 2'd3; par_en = 1'b1;
      par_odd = 1'b0;
      expect_item(8'h96, 1'b0, 1'b0, 1'b0); send_frame(8'h96, 8, 1'b0, 1'b1, 1'b0);
      expect_item(8'h97, 1'b1, 1'b0, 1'b0); send_frame(8'h97, 8, 1'b1, 1'b1, 1'b0);
      par_odd = 1'b1;
      expect_item(8'h3C, 1'b0, 1'b0, 1'b0); send_frame(8'h3C, 8, 1'b0, 1'b1, 1'b0);
      expect_item(8'h01, 1'b1, 1'b0, 1'b0); send_frame(8'h01, 8, 1'b1, 1'b1, 1'b0);
      width_sel = 2'd1;
      expect_item(8'h25, 1'b0, 1'b0, 1'b0); send_frame(8'h25, 6, 1'b0, 1'b1, 1'b0);
      par_en = 1'b0; width_sel = 2'd3;
      drain("R3");

      // R5: framing error with nonzero data
      expect_item(8'h81, 1'b0, 1'b1, 1'b0); send_frame(8'h81, 8, 1'b0, 1'b0, 1'b0);
      send_ok(8'h6A, 8);
      drain("R5");

      // R6: break
      rx_pin = 1'b0;
      expect_item(8'h00, 1'b0, 1'b0, 1'b1);
      repeat (15 * bit_clks()) @(negedge clk);
      check(line_break == 1'b1, "R6", "line_break during hold", line_break, 1);
      repeat (5 * bit_clks()) @(negedge clk);
      rx_pin = 1'b1;
      repeat (10) @(negedge clk);
      check(line_break == 1'b0, "R6", "line_break after release", line_break, 0);
      repeat (2 * bit_clks()) @(negedge clk);
      send_ok(8'h5A, 8);
      drain("R6");

      // R4: glitch rejected, next frame fine
      rx_pin = 1'b0;
      repeat (6) @(negedge clk);
      rx_pin = 1'b1;
      repeat (3 * bit_clks()) @(negedge clk);
      check(fifo_empty == 1'b1, "R4", "glitch stored", fifo_count, 0);
      send_ok(8'hC7, 8);
      drain("R4");

      // R9: loopback takes tx_loop, ignores rx_pin
      loop_en = 1'b1;
      rx_pin = 1'b0;
      expect_item(8'hC3, 1'b0, 1'b0, 1'b0);
      send_frame(8'hC3, 8, 1'b0, 1'b1, 1'b1);
      drain("R9");
      check(line_break == 1'b0, "R9", "pin low seen in loopback", line_break, 0);
      rx_pin = 1'b1;
      loop_en = 1'b0;
      repeat (10) @(negedge clk);
      send_frame(8'h11, 8, 1'b0, 1'b1, 1'b1);
      repeat (10) @(negedge clk);
      check(fifo_empty == 1'b1, "R9", "tx_loop leaked when off", fifo_count, 0);

      // R10: tick held low stores nothing; fast tick still works
      tick_div = 0;
      send_frame(8'h42, 8, 1'b0, 1'b1, 1'b0);
      repeat (10) @(negedge clk);
      check(fifo_empty == 1'b1, "R10", "stored without tick", fifo_count, 0);
      tick_div = 1;
      repeat (40) @(negedge clk);
      send_ok(8'hB9, 8);
      drain("R10");

      // R7/R8: fill 64 with reads stalled, then one more is lost
      mon_en = 1'b0;
      repeat (4) @(negedge clk);
      for (int i = 0; i < 64; i++) send_ok(8'(i * 7 + 3), 8);
      check(fifo_full == 1'b1, "R7", "full at 64", fifo_full, 1);
      check(fifo_count == 64, "R7", "count at 64", fifo_count, 64);
      check(overrun == 1'b0, "R8", "overrun before loss", overrun, 0);
      send_frame(8'hEE, 8, 1'b0, 1'b1, 1'b0);
      check(overrun == 1'b1, "R8", "overrun after loss", overrun, 1);
      check(fifo_count == 64, "R8", "count after loss", fifo_count, 64);
      mon_en = 1'b1;
      while (fifo_count == 64) @(negedge clk);
      check(overrun == 1'b0, "R8", "overrun after read", overrun, 0);
      drain("R7");
      check(fifo_empty == 1'b1, "R7", "empty at end", fifo_empty, 1);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule